// File: doc/BRIEF.md
# Processor Power-Down Mode Controller

This block chooses the low-power state that a processor core enters when it executes a wait instruction, and it brings the core back out of that state. The choice depends on two control bits, a standby enable and a deep enable. The controller samples them in the cycle that the wait-for-interrupt (WFI) or wait-for-event (WFE) pulse arrives. A write to those bits never starts a transition by itself. The possible states are light sleep, where only the CPU clock stops, software standby, where every clock stops but power stays on, and deep standby, where the main power domain is switched off and only the selected retention RAM pages stay powered.

Wake-up follows the kind of wait that was used. WFI sleep wakes on any raised interrupt line, whether or not that line is masked. WFE sleep wakes only on a request the CPU has unmasked, or on NMI. A one-bit event latch lets a WFE return at once after a send-event (SEV). When the core leaves deep standby, power comes back on, the core is held in reset for a fixed settle time, and a wake-source flag is recorded. An NMI that arrives together with the deep entry cancels that entry.

Software reaches three registers over a small write/read bus. Address 0 holds the control bits. Address 1 holds the retention page mask. Address 2 holds the wake flags.

Top module: `pwrdn_ctrl`

## Requirements
- R1: After reset the core is running: the CPU clock enable, the peripheral clock enable and the clock-output enable are 1, the power-off request is 0, the core reset is 0, every retention page enable is 1, and all three registers read 0.
- R2: A WFI pulse while the standby enable (address 0 bit 0) is 0 enters sleep. From the cycle after the pulse, the CPU clock enable is 0 and the peripheral and clock-output enables stay 1.
- R3: WFI sleep ends on the next clock edge at which any interrupt line, the fast interrupt line or NMI is high. The two mask inputs have no effect on this.
- R4: WFE sleep ends only when an unmasked request is present or NMI is high. An unmasked request is an interrupt line high while the IRQ mask is 0, or the fast interrupt line high while the FIQ mask is 0. A request that is masked leaves the core asleep.
- R5: The event latch is set by SEV, and also by any interrupt request seen while the core is running. A WFE that finds the latch set clears it and the core keeps running. The WFE after that one sleeps.
- R6: The core leaves the running state only on a cycle that carries a WFI or WFE pulse. Writing the standby enable, including a 0-to-1 write just after a wake from sleep, changes no output.
- R7: A WFI with the standby enable 1 and the deep enable (address 0 bit 1) 0 enters software standby. All three clock enables are 0 and the power-off request is 0. Any interrupt line, the fast interrupt line or NMI returns the core to running on the next edge.
- R8: A WFI with both enables 1 passes through one entry cycle, with clocks off and power on, and then enters deep standby. In deep standby the power-off request is 1 and the retention page enables equal the keep mask (address 1, bit n for page n). In every other state all page enables are 1.
- R9: If NMI is high in the cycle of the deep-standby WFI, or in the entry cycle, the entry is abandoned and the core is running again from the next cycle.
- R10: Any interrupt line, the fast interrupt line or NMI ends deep standby. The power-off request drops and the core reset is held at 1 for exactly SETTLE_CYC cycles, after which the core runs. At that point the flag register gets bit 0 set for an NMI wake and bit 1 set for an interrupt wake, and the control register is cleared to 0.
- R11: Writing address 2 clears each flag bit whose write-data bit is 1 and leaves every other flag bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wfi_i | input | 1 | WFI executed (one-cycle pulse) |
| wfe_i | input | 1 | WFE executed (one-cycle pulse) |
| sev_i | input | 1 | SEV executed (one-cycle pulse) |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | DW | Register write data |
| bus_rdata_o | output | DW | Register read data (combinational) |
| irq_i | input | NUM_IRQ | Interrupt request lines |
| fiq_i | input | 1 | Fast interrupt request |
| irq_mask_i | input | 1 | CPU IRQ mask bit |
| fiq_mask_i | input | 1 | CPU FIQ mask bit |
| nmi_i | input | 1 | Non-maskable interrupt |
| cpu_clk_en_o | output | 1 | CPU clock gate enable |
| per_clk_en_o | output | 1 | Peripheral clock gate enable |
| clk_out_en_o | output | 1 | External clock-output enable |
| main_pwr_off_o | output | 1 | Main-domain power-off request |
| core_rst_o | output | 1 | Core reset during post-wake settle |
| ram_keep_o | output | PAGES | Retention page power enables |

## Verification
The bench goes after the mask cases that split the two sleep kinds. It holds a masked request against WFI sleep, which must wake, and against WFE sleep, which must stay asleep. A design that mixes these up either hangs under WFI or wakes WFE sleep too early. It writes the standby enable from 0 to 1 right after a sleep wake; a design with the old flaw would drop into standby at the write. NMI is raised in the deep-entry WFI cycle and in the entry cycle; a wrong design powers off anyway. The bench counts the reset-hold cycles after a deep wake, checks the flag bit for each source, checks that the control register was cleared, and checks that SEV lets exactly one WFE through.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;

  typedef enum logic [2:0] {
    PS_RUN,
    PS_SLEEP,
    PS_SSTBY,
    PS_DENTRY,
    PS_DSTBY,
    PS_DSETTLE
  } pstate_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_KEEP = 2'd1;
  localparam logic [1:0] ADDR_FLAG = 2'd2;

  localparam int NUM_FLAGS = 2;
  localparam int FLAG_NMI  = 0;
  localparam int FLAG_IRQ  = 1;

endpackage

// File: rtl/pwrdn_regs.sv
module pwrdn_regs
  import pwrdn_pkg::*;
#(
  parameter int DW    = 8,
  parameter int PAGES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_i,
  input  logic [1:0]           addr_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o,
  input  logic                 settle_done_i,
  input  logic [NUM_FLAGS-1:0] wake_src_i,
  output logic                 standby_en_o,
  output logic                 deep_en_o,
  output logic [PAGES-1:0]     keep_o
);

  logic                 sb_q, sb_d, dp_q, dp_d;
  logic [PAGES-1:0]     keep_q, keep_d;
  logic [NUM_FLAGS-1:0] flag_q, flag_d, flag_clr;
  logic                 wr_ctrl, wr_keep, wr_flag, reg_en;

  assign wr_ctrl = wr_i && (addr_i == ADDR_CTRL);
  assign wr_keep = wr_i && (addr_i == ADDR_KEEP);
  assign wr_flag = wr_i && (addr_i == ADDR_FLAG);
  assign reg_en  = wr_i || settle_done_i;

  always_comb begin
    sb_d   = sb_q;
    dp_d   = dp_q;
    keep_d = keep_q;
    if (wr_ctrl) begin
      sb_d = wdata_i[0];
      dp_d = wdata_i[1];
    end
    if (wr_keep) keep_d = wdata_i[PAGES-1:0];
    if (settle_done_i) begin
      sb_d = 1'b0;
      dp_d = 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    assign flag_clr[g] = wr_flag && wdata_i[g];
    assign flag_d[g]   = (settle_done_i && wake_src_i[g]) ||
                         (flag_q[g] && !flag_clr[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sb_q   <= 1'b0;
      dp_q   <= 1'b0;
      keep_q <= '0;
      flag_q <= '0;
    end else if (reg_en) begin
      sb_q   <= sb_d;
      dp_q   <= dp_d;
      keep_q <= keep_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_CTRL: rdata_o[1:0]           = {dp_q, sb_q};
      ADDR_KEEP: rdata_o[PAGES-1:0]     = keep_q;
      ADDR_FLAG: rdata_o[NUM_FLAGS-1:0] = flag_q;
      default:   rdata_o                = '0;
    endcase
  end

  assign standby_en_o = sb_q;
  assign deep_en_o    = dp_q;
  assign keep_o       = keep_q;

  p_flag_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    settle_done_i |=> ((flag_q & $past(wake_src_i)) == $past(wake_src_i)));

  p_ctrl_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    settle_done_i |=> (!sb_q && !dp_q));

  p_flag_w1c_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flag && !settle_done_i) |=> ((flag_q & $past(wdata_i[NUM_FLAGS-1:0])) == '0));

endmodule

// File: rtl/pwrdn_wake.sv
module pwrdn_wake #(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               fiq_i,
  input  logic               irq_mask_i,
  input  logic               fiq_mask_i,
  input  logic               sev_i,
  input  logic               wfe_i,
  input  logic               wfi_i,
  input  logic               in_run_i,
  output logic               any_req_o,
  output logic               unmasked_req_o,
  output logic               evt_o
);

  logic irq_any;
  logic evt_q, evt_d, evt_set, evt_use, evt_en;

  assign irq_any        = |irq_i;
  assign any_req_o      = irq_any || fiq_i;
  assign unmasked_req_o = (irq_any && !irq_mask_i) || (fiq_i && !fiq_mask_i);

  assign evt_set = sev_i || (in_run_i && any_req_o);
  assign evt_use = in_run_i && wfe_i && !wfi_i && evt_q;
  assign evt_en  = evt_set || evt_use;

  always_comb begin
    evt_d = evt_q;
    if (evt_use) evt_d = 1'b0;
    if (evt_set) evt_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      evt_q <= 1'b0;
    else if (evt_en) evt_q <= evt_d;
  end

  assign evt_o = evt_q;

  p_evt_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sev_i |=> evt_q);

  p_evt_use_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run_i && wfe_i && !wfi_i && evt_q && !sev_i && !any_req_o) |=> !evt_q);

endmodule

// File: rtl/pwrdn_fsm.sv
module pwrdn_fsm
  import pwrdn_pkg::*;
#(
  parameter int SETTLE_CYC = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wfi_i,
  input  logic                 wfe_i,
  input  logic                 evt_i,
  input  logic                 standby_en_i,
  input  logic                 deep_en_i,
  input  logic                 any_req_i,
  input  logic                 unmasked_req_i,
  input  logic                 nmi_i,
  output pstate_e              state_o,
  output logic                 settle_done_o,
  output logic [NUM_FLAGS-1:0] wake_src_o
);

  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(SETTLE_CYC - 1);

  pstate_e              state_q, state_d;
  logic                 wfe_mode_q, wfe_mode_d;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic [NUM_FLAGS-1:0] src_q, src_d;
  logic                 deep_wake;

  assign deep_wake     = any_req_i || nmi_i;
  assign settle_done_o = (state_q == PS_DSETTLE) && (cnt_q == CNT_LAST);

  always_comb begin
    state_d    = state_q;
    wfe_mode_d = wfe_mode_q;
    cnt_d      = cnt_q;
    src_d      = src_q;
    case (state_q)
      PS_RUN: begin
        if (wfi_i) begin
          wfe_mode_d = 1'b0;
          if (!standby_en_i)   state_d = PS_SLEEP;
          else if (!deep_en_i) state_d = PS_SSTBY;
          else if (!nmi_i)     state_d = PS_DENTRY;
        end else if (wfe_i && !evt_i) begin
          wfe_mode_d = 1'b1;
          state_d    = PS_SLEEP;
        end
      end
      PS_SLEEP: begin
        if (wfe_mode_q) begin
          if (unmasked_req_i || nmi_i) state_d = PS_RUN;
        end else if (any_req_i || nmi_i) begin
          state_d = PS_RUN;
        end
      end
      PS_SSTBY: begin
        if (any_req_i || nmi_i) state_d = PS_RUN;
      end
      PS_DENTRY: begin
        state_d = nmi_i ? PS_RUN : PS_DSTBY;
      end
      PS_DSTBY: begin
        if (deep_wake) begin
          state_d               = PS_DSETTLE;
          cnt_d                 = '0;
          src_d                 = '0;
          src_d[FLAG_NMI]       = nmi_i;
          src_d[FLAG_IRQ]       = any_req_i;
        end
      end
      PS_DSETTLE: begin
        if (cnt_q == CNT_LAST) state_d = PS_RUN;
        else                   cnt_d   = cnt_q + 1'b1;
      end
      default: state_d = PS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= PS_RUN;
      wfe_mode_q <= 1'b0;
      cnt_q      <= '0;
      src_q      <= '0;
    end else begin
      state_q    <= state_d;
      wfe_mode_q <= wfe_mode_d;
      cnt_q      <= cnt_d;
      src_q      <= src_d;
    end
  end

  assign state_o    = state_q;
  assign wake_src_o = src_q;

  p_run_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_RUN && !wfi_i && !wfe_i) |=> (state_q == PS_RUN));

  p_wfi_wake_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_SLEEP && !wfe_mode_q && any_req_i) |=> (state_q == PS_RUN));

  p_wfe_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_SLEEP && wfe_mode_q && !unmasked_req_i && !nmi_i) |=> (state_q == PS_SLEEP));

  p_nmi_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_DENTRY && nmi_i) |=> (state_q == PS_RUN));

  p_settle_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_DSETTLE) |-> (cnt_q < CW'(SETTLE_CYC)));

endmodule

// File: rtl/pwrdn_outdec.sv
module pwrdn_outdec
  import pwrdn_pkg::*;
#(
  parameter int PAGES = 4
) (
  input  pstate_e          state_i,
  input  logic [PAGES-1:0] keep_i,
  output logic             cpu_clk_en_o,
  output logic             per_clk_en_o,
  output logic             clk_out_en_o,
  output logic             main_pwr_off_o,
  output logic             core_rst_o,
  output logic [PAGES-1:0] ram_keep_o
);

  logic in_deep;

  assign in_deep        = (state_i == PS_DSTBY);
  assign cpu_clk_en_o   = (state_i == PS_RUN);
  assign per_clk_en_o   = (state_i == PS_RUN) || (state_i == PS_SLEEP);
  assign clk_out_en_o   = per_clk_en_o;
  assign main_pwr_off_o = in_deep;
  assign core_rst_o     = (state_i == PS_DSETTLE);

  for (genvar p = 0; p < PAGES; p++) begin : g_page
    assign ram_keep_o[p] = !in_deep || keep_i[p];
  end

endmodule

// File: rtl/pwrdn_ctrl.sv
module pwrdn_ctrl
  import pwrdn_pkg::*;
#(
  parameter int NUM_IRQ    = 8,
  parameter int PAGES      = 4,
  parameter int DW         = 8,
  parameter int SETTLE_CYC = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wfi_i,
  input  logic               wfe_i,
  input  logic               sev_i,
  input  logic               bus_wr_i,
  input  logic [1:0]         bus_addr_i,
  input  logic [DW-1:0]      bus_wdata_i,
  output logic [DW-1:0]      bus_rdata_o,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               fiq_i,
  input  logic               irq_mask_i,
  input  logic               fiq_mask_i,
  input  logic               nmi_i,
  output logic               cpu_clk_en_o,
  output logic               per_clk_en_o,
  output logic               clk_out_en_o,
  output logic               main_pwr_off_o,
  output logic               core_rst_o,
  output logic [PAGES-1:0]   ram_keep_o
);

  pstate_e              state;
  logic                 settle_done, standby_en, deep_en;
  logic                 any_req, unmasked_req, evt;
  logic [NUM_FLAGS-1:0] wake_src;
  logic [PAGES-1:0]     keep_mask;

  pwrdn_regs #(.DW(DW), .PAGES(PAGES)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_i         (bus_wr_i),
    .addr_i       (bus_addr_i),
    .wdata_i      (bus_wdata_i),
    .rdata_o      (bus_rdata_o),
    .settle_done_i(settle_done),
    .wake_src_i   (wake_src),
    .standby_en_o (standby_en),
    .deep_en_o    (deep_en),
    .keep_o       (keep_mask)
  );

  pwrdn_wake #(.NUM_IRQ(NUM_IRQ)) u_wake (
    .clk           (clk),
    .rst_n         (rst_n),
    .irq_i         (irq_i),
    .fiq_i         (fiq_i),
    .irq_mask_i    (irq_mask_i),
    .fiq_mask_i    (fiq_mask_i),
    .sev_i         (sev_i),
    .wfe_i         (wfe_i),
    .wfi_i         (wfi_i),
    .in_run_i      (state == PS_RUN),
    .any_req_o     (any_req),
    .unmasked_req_o(unmasked_req),
    .evt_o         (evt)
  );

  pwrdn_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .wfi_i         (wfi_i),
    .wfe_i         (wfe_i),
    .evt_i         (evt),
    .standby_en_i  (standby_en),
    .deep_en_i     (deep_en),
    .any_req_i     (any_req),
    .unmasked_req_i(unmasked_req),
    .nmi_i         (nmi_i),
    .state_o       (state),
    .settle_done_o (settle_done),
    .wake_src_o    (wake_src)
  );

  pwrdn_outdec #(.PAGES(PAGES)) u_out (
    .state_i       (state),
    .keep_i        (keep_mask),
    .cpu_clk_en_o  (cpu_clk_en_o),
    .per_clk_en_o  (per_clk_en_o),
    .clk_out_en_o  (clk_out_en_o),
    .main_pwr_off_o(main_pwr_off_o),
    .core_rst_o    (core_rst_o),
    .ram_keep_o    (ram_keep_o)
  );

  p_pwr_clk_r8: assert property (@(posedge clk) disable iff (!rst_n)
    main_pwr_off_o |-> (!cpu_clk_en_o && !per_clk_en_o && !clk_out_en_o));

  p_wfi_sleep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en_o && wfi_i && !standby_en) |=> (!cpu_clk_en_o && per_clk_en_o));

endmodule

// File: tb/tb_pwrdn_ctrl.sv
module tb_pwrdn_ctrl;

  localparam int NUM_IRQ = 8;
  localparam int PAGES   = 4;
  localparam int DW      = 8;
  localparam int SETTLE  = 16;

  logic               clk, rst_n;
  logic               wfi, wfe, sev, bus_wr, fiq, irq_mask, fiq_mask, nmi;
  logic [1:0]         bus_addr;
  logic [DW-1:0]      bus_wdata, bus_rdata;
  logic [NUM_IRQ-1:0] irq;
  logic               cpu_en, per_en, cko_en, pwr_off, core_rst;
  logic [PAGES-1:0]   keep;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  pwrdn_ctrl #(.NUM_IRQ(NUM_IRQ), .PAGES(PAGES), .DW(DW), .SETTLE_CYC(SETTLE)) dut (
    .clk(clk), .rst_n(rst_n), .wfi_i(wfi), .wfe_i(wfe), .sev_i(sev),
    .bus_wr_i(bus_wr), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .irq_i(irq), .fiq_i(fiq), .irq_mask_i(irq_mask), .fiq_mask_i(fiq_mask), .nmi_i(nmi),
    .cpu_clk_en_o(cpu_en), .per_clk_en_o(per_en), .clk_out_en_o(cko_en),
    .main_pwr_off_o(pwr_off), .core_rst_o(core_rst), .ram_keep_o(keep)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Expected clock/power vector {cpu, per, clkout, pwr_off}
  localparam logic [3:0] V_RUN   = 4'b1110;
  localparam logic [3:0] V_SLEEP = 4'b0110;
  localparam logic [3:0] V_STBY  = 4'b0000;
  localparam logic [3:0] V_DEEP  = 4'b0001;

  function automatic logic [3:0] vec();
    return {cpu_en, per_en, cko_en, pwr_off};
  endfunction

  // mode 0: WFI sleep, 1: WFE sleep, 2: software standby
  function automatic bit exp_wake(int mode, logic [NUM_IRQ-1:0] q, logic f,
                                  logic mi, logic mf, logic n);
    bit any_r = (|q) || f;
    bit unm_r = ((|q) && !mi) || (f && !mf);
    if (mode == 1) return unm_r || n;
    return any_r || n;
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [DW-1:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pulse_wfi();
    @(negedge clk); wfi = 1'b1;
    @(negedge clk); wfi = 1'b0;
  endtask

  task automatic pulse_wfe();
    @(negedge clk); wfe = 1'b1;
    @(negedge clk); wfe = 1'b0;
  endtask

  task automatic pulse_sev();
    @(negedge clk); sev = 1'b1;
    @(negedge clk); sev = 1'b0;
  endtask

  // leave the event latch known clear (requires no request pending)
  task automatic drain_evt();
    pulse_sev();
    pulse_wfe();
  endtask

  task automatic wake_nmi();
    nmi = 1'b1;
    @(negedge clk);
    nmi = 1'b0;
  endtask

  initial begin
    #2000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd;
    int n;
    wfi = 0; wfe = 0; sev = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    irq = 0; fiq = 0; irq_mask = 0; fiq_mask = 0; nmi = 0;
    rst_n = 1'b0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(vec(), V_RUN, "R1 clocks after reset");
    check(core_rst, 0, "R1 core reset");
    check(keep, 4'hF, "R1 page enables");
    reg_rd(2'd0, rd); check(rd, 0, "R1 ctrl reg");
    reg_rd(2'd1, rd); check(rd, 0, "R1 keep reg");
    reg_rd(2'd2, rd); check(rd, 0, "R1 flag reg");

    // R2 / R3 WFI sleep, woken by a masked interrupt
    pulse_wfi();
    check(vec(), V_SLEEP, "R2 WFI enters sleep");
    repeat (2) @(negedge clk);
    check(vec(), V_SLEEP, "R2 sleep holds");
    irq_mask = 1; fiq_mask = 1; irq = 8'h08;
    @(negedge clk);
    check(vec(), V_RUN, "R3 masked irq wakes WFI sleep");
    irq = 0;

    // R6 STBY 0->1 right after the wake must not enter standby
    reg_wr(2'd0, 8'h01);
    repeat (3) @(negedge clk);
    check(vec(), V_RUN, "R6 standby write alone keeps run");
    reg_rd(2'd0, rd); check(rd, 8'h01, "R6 ctrl readback");

    // R7 software standby
    pulse_wfi();
    check(vec(), V_STBY, "R7 standby clocks off power on");
    repeat (2) @(negedge clk);
    check(vec(), V_STBY, "R7 standby holds");
    fiq = 1;
    @(negedge clk);
    check(vec(), V_RUN, "R7 masked fiq resumes from standby");
    fiq = 0;
    reg_wr(2'd0, 8'h00);

    // R4 WFE sleep ignores masked requests
    irq_mask = 1; fiq_mask = 1;
    drain_evt();
    check(vec(), V_RUN, "R5 WFE after SEV returns at once");
    pulse_wfe();
    check(vec(), V_SLEEP, "R5 second WFE sleeps");
    irq = 8'h81; fiq = 1;
    repeat (3) @(negedge clk);
    check(vec(), V_SLEEP, "R4 masked requests leave WFE sleep");
    irq_mask = 0;
    @(negedge clk);
    check(vec(), V_RUN, "R4 unmasked irq wakes WFE sleep");
    irq = 0; fiq = 0; irq_mask = 1;
    drain_evt();
    pulse_wfe();
    check(vec(), V_SLEEP, "R4 WFE sleep again");
    wake_nmi();
    check(vec(), V_RUN, "R4 NMI wakes WFE sleep");

    // R5 request in run sets the latch
    irq = 8'h02;
    @(negedge clk);
    irq = 0;
    pulse_wfe();
    check(vec(), V_RUN, "R5 request-set latch lets WFE through");
    pulse_wfe();
    check(vec(), V_SLEEP, "R5 latch consumed");
    wake_nmi();

    // R8 / R10 deep standby, irq wake
    reg_wr(2'd1, 8'h0A);
    reg_wr(2'd0, 8'h03);
    pulse_wfi();
    check(vec(), V_STBY, "R8 entry cycle clocks off power on");
    @(negedge clk);
    check(vec(), V_DEEP, "R8 deep power off");
    check(keep, 4'hA, "R8 keep mask in deep");
    repeat (4) @(negedge clk);
    check(vec(), V_DEEP, "R8 deep holds");
    irq = 8'h40;
    @(negedge clk);
    irq = 0;
    check(pwr_off, 0, "R10 power restored");
    check(keep, 4'hF, "R8 pages on outside deep");
    n = 0;
    while (core_rst && n < 100) begin n++; @(negedge clk); end
    check(n, SETTLE, "R10 reset hold length");
    check(vec(), V_RUN, "R10 running after settle");
    reg_rd(2'd2, rd); check(rd, 8'h02, "R10 irq wake flag");
    reg_rd(2'd0, rd); check(rd, 8'h00, "R10 ctrl cleared");

    // R11 write-1-to-clear
    reg_wr(2'd2, 8'h01);
    reg_rd(2'd2, rd); check(rd, 8'h02, "R11 clearing other bit keeps flag");
    reg_wr(2'd2, 8'h02);
    reg_rd(2'd2, rd); check(rd, 8'h00, "R11 flag cleared");

    // R10 NMI deep wake
    reg_wr(2'd0, 8'h03);
    pulse_wfi();
    @(negedge clk);
    check(vec(), V_DEEP, "R8 deep again");
    wake_nmi();
    n = 0;
    while (core_rst && n < 100) begin n++; @(negedge clk); end
    check(n, SETTLE, "R10 reset hold length nmi");
    reg_rd(2'd2, rd); check(rd, 8'h01, "R10 nmi wake flag");
    reg_wr(2'd2, 8'h03);

    // R9 NMI with the WFI cycle
    reg_wr(2'd0, 8'h03);
    @(negedge clk);
    wfi = 1; nmi = 1;
    @(negedge clk);
    wfi = 0; nmi = 0;
    check(vec(), V_RUN, "R9 NMI in WFI cycle cancels deep");
    // R9 NMI in entry cycle
    pulse_wfi();
    check(vec(), V_STBY, "R9 entry cycle reached");
    wake_nmi();
    check(vec(), V_RUN, "R9 NMI in entry cycle cancels deep");
    repeat (2) @(negedge clk);
    check(pwr_off, 0, "R9 power never dropped");
    reg_wr(2'd0, 8'h00);

    // random trials over R3 / R4 / R7
    for (int t = 0; t < 60; t++) begin
      int mode;
      logic [NUM_IRQ-1:0] q;
      logic f, n_in, w;
      mode = int'($urandom_range(0, 2));
      irq_mask = 1'($urandom_range(0, 1));
      fiq_mask = 1'($urandom_range(0, 1));
      q = ($urandom_range(0, 2) == 0) ? '0 : NUM_IRQ'($urandom);
      f = 1'($urandom_range(0, 1));
      n_in = ($urandom_range(0, 7) == 0);
      drain_evt();
      reg_wr(2'd0, (mode == 2) ? 8'h01 : 8'h00);
      if (mode == 1) pulse_wfe(); else pulse_wfi();
      check(vec(), (mode == 2) ? V_STBY : V_SLEEP, "R2 R4 R7 random entry");
      irq = q; fiq = f; nmi = n_in;
      @(negedge clk);
      w = exp_wake(mode, q, f, irq_mask, fiq_mask, n_in);
      irq = 0; fiq = 0; nmi = 0;
      if (mode == 1) check(vec(), w ? V_RUN : V_SLEEP, "R4 random WFE wake");
      else if (mode == 0) check(vec(), w ? V_RUN : V_SLEEP, "R3 random WFI wake");
      else check(vec(), w ? V_RUN : V_STBY, "R7 random standby wake");
      if (!w) wake_nmi();
    end
    reg_wr(2'd0, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    done = 1;
    $finish;
  end

endmodule